// File: doc/BRIEF.md
# Synchronized Even-Ratio Clock Output Channel

This block is one output lane of a multi-output clock distributor; a bank is built by placing eight of them side by side on the same distribution clock. Each lane either passes the distribution clock straight through or emits a divided copy whose ratio is twice an 8-bit code, so ratios from 2 to 510 in even steps are available. A 2-bit mode input picks the path. Two of the four modes also request a fine delay, which is not modelled here, so each delayed mode uses the same source as its undelayed partner.

All lanes share an active-low alignment input. A low level must be seen on two consecutive clock edges before it counts. After a fixed pipeline, every lane in a divided mode then holds its output low. When the input returns high, every divided lane starts a fresh high phase on the same clock edge. Lanes in pass-through ignore this input.

An output is live only when three enables are all 1: the lane's own bit, a bank-wide register bit and a bank-wide pin. A powerdown input overrides everything. When an output is not live it is driven to constant 0, and a separate status bit reports it as off. A divide code of 0 is not a legal setting. The lane still divides by 2 and raises a flag.

Top module: `evendiv_clk_channel`

## Requirements
- R1: While reset is asserted and after it is released with every enable at 0, `clk_o` is 0 and `off_o` is 1.
- R2: In mode 0 (pass-through) and mode 2 (delayed, treated as pass-through), with the lane live, `clk_o` equals the distribution clock level.
- R3: In mode 1 (divided) and mode 3 (divided and delayed) with code N from 1 to 255, the output is high for N clock cycles and then low for N cycles, giving a period of 2N cycles.
- R4: `cfg_bad_o` is 1 exactly when the divide code is 0. Code 0 divides by 2.
- R5: Two consecutive clock edges that sample `sync_n` low qualify a hold. The divided output is low after the 4th edge following the second low sample and stays low while the hold lasts.
- R6: A `sync_n` low that is sampled on only one edge, with high samples on both sides, does not disturb the divided output.
- R7: After a hold, if `sync_n` is first sampled high at edge k, the divided output goes high after edge k+4 and starts a fresh high phase of N cycles.
- R8: In modes 0 and 2 the output keeps following the clock while `sync_n` is low.
- R9: The lane is live only when `ch_en`, `glob_en_bit` and `glob_en_pin` are all 1. Otherwise `off_o` is 1 and `clk_o` is 0.
- R10: When `pwrdn` is 1, `off_o` is 1 and `clk_o` is 0, whatever the other inputs are.
- R11: On a change from a pass-through mode to a divided mode, the divider starts a fresh high phase at the first clock edge that samples the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected distribution clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low bank alignment input |
| mode | input | 2 | Path select: 0 pass, 1 divided, 2 delayed-pass, 3 delayed-divided |
| div_code | input | 8 | Divide code N; ratio is 2N |
| ch_en | input | 1 | Lane enable bit |
| glob_en_bit | input | 1 | Bank-wide enable register bit |
| glob_en_pin | input | 1 | Bank-wide enable pin |
| pwrdn | input | 1 | Powerdown, overrides all enables |
| clk_o | output | 1 | Lane clock output, 0 when off |
| off_o | output | 1 | 1 when the lane output is off |
| cfg_bad_o | output | 1 | 1 when the divide code is 0 |

## Verification
The hardest condition to reach from the ports is the edge of the low-qualification window. A single-sample low must leave the divider untouched, while a two-sample low must force it low exactly four edges later. Both can line up against any phase of a running divide period. The stimulus drives `sync_n` on falling edges for exactly one and then several cycles while a divided mode is running. A cycle-accurate model in the bench predicts the output at both clock levels, so a release edge that comes one cycle early or late, or a mis-restarted phase, shows up as a mismatch. The longest ratio, code 255, is run for more than a full period to cover the counter boundary.

// File: rtl/evendiv_pkg.sv
`timescale 1ns/1ps
package evendiv_pkg;

   typedef enum logic [1:0] {
      PATH_PASS     = 2'd0,
      PATH_DIV      = 2'd1,
      PATH_DLY      = 2'd2,
      PATH_DIV_DLY  = 2'd3
   } path_mode_e;

   // true for the two modes that route through the divider
   function automatic logic uses_divider(input logic [1:0] m);
      return (m == PATH_DIV) || (m == PATH_DIV_DLY);
   endfunction

endpackage

// File: rtl/evendiv_sync_qual.sv
`timescale 1ns/1ps
module evendiv_sync_qual #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_n,
   output logic hold_o
);
   localparam int CHAIN = LATENCY - 1;

   if (LATENCY < 2) begin : g_bad_latency
      $error("evendiv_sync_qual: LATENCY must be at least 2");
   end

   logic prev_q;
   logic req_q;
   logic [CHAIN-1:0] pipe_q;

   // a low counts only when two consecutive samples are low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         req_q  <= 1'b0;
      end else begin
         prev_q <= sync_n;
         if (sync_n)
            req_q <= 1'b0;
         else if (!prev_q)
            req_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe_q[i] <= 1'b0;
         else if (i == 0)
            pipe_q[i] <= req_q;
         else
            pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
      end
   end

   assign hold_o = pipe_q[CHAIN-1];
endmodule

// File: rtl/evendiv_divider.sv
`timescale 1ns/1ps
module evendiv_divider #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              act_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              div_q_o,
   output logic              bad_o
);
   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_width
      $error("evendiv_divider: CODE_W out of range");
   end

   logic [CODE_W-1:0] eff_code;
   logic [CODE_W-1:0] reload;
   logic [CODE_W-1:0] cnt_q;
   logic              out_q;
   logic              pend_q;

   assign bad_o    = (code_i == '0);
   assign eff_code = bad_o ? CODE_W'(1) : code_i;
   assign reload   = eff_code - CODE_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= 1'b0;
         cnt_q  <= '0;
         pend_q <= 1'b1;
      end else if (hold_i || !act_i) begin
         out_q  <= 1'b0;
         cnt_q  <= '0;
         pend_q <= 1'b1;
      end else if (pend_q) begin
         out_q  <= 1'b1;
         cnt_q  <= reload;
         pend_q <= 1'b0;
      end else if (cnt_q == '0) begin
         out_q  <= ~out_q;
         cnt_q  <= reload;
      end else begin
         cnt_q  <= cnt_q - CODE_W'(1);
      end
   end

   assign div_q_o = out_q;
endmodule

// File: rtl/evendiv_out_gate.sv
`timescale 1ns/1ps
module evendiv_out_gate (
   input  logic clk,
   input  logic use_div,
   input  logic div_q,
   input  logic ch_en,
   input  logic glob_en_bit,
   input  logic glob_en_pin,
   input  logic pwrdn,
   output logic clk_o,
   output logic off_o
);
   logic live;
   logic src;

   always_comb begin
      live  = ch_en & glob_en_bit & glob_en_pin & ~pwrdn;
      src   = use_div ? div_q : clk;
      clk_o = live & src;
      off_o = ~live;
   end
endmodule

// File: rtl/evendiv_clk_channel.sv
`timescale 1ns/1ps
module evendiv_clk_channel
   import evendiv_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int SYNC_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic [1:0]        mode,
   input  logic [CODE_W-1:0] div_code,
   input  logic              ch_en,
   input  logic              glob_en_bit,
   input  logic              glob_en_pin,
   input  logic              pwrdn,
   output logic              clk_o,
   output logic              off_o,
   output logic              cfg_bad_o
);
   logic hold_w;
   logic act_w;
   logic div_q_w;

   assign act_w = uses_divider(mode);

   evendiv_sync_qual #(.LATENCY(SYNC_LAT)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_n (sync_n),
      .hold_o (hold_w)
   );

   evendiv_divider #(.CODE_W(CODE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_i  (hold_w),
      .act_i   (act_w),
      .code_i  (div_code),
      .div_q_o (div_q_w),
      .bad_o   (cfg_bad_o)
   );

   evendiv_out_gate u_gate (
      .clk         (clk),
      .use_div     (act_w),
      .div_q       (div_q_w),
      .ch_en       (ch_en),
      .glob_en_bit (glob_en_bit),
      .glob_en_pin (glob_en_pin),
      .pwrdn       (pwrdn),
      .clk_o       (clk_o),
      .off_o       (off_o)
   );
endmodule

// File: rtl/evendiv_clk_channel_chk.sv
`timescale 1ns/1ps
module evendiv_clk_channel_chk (
   input logic clk,
   input logic rst_n,
   input logic sync_n,
   input logic pwrdn,
   input logic clk_o,
   input logic off_o,
   input logic hold,
   input logic act,
   input logic div_q
);
   // R5
   hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_n && !$past(sync_n)) |-> ##4 hold);

   // R7
   hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |-> ##4 !hold);

   // R5
   div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !div_q);

   // R11
   div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && act && $past(hold || !act)) |=> div_q);

   // R10
   pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |-> (off_o && !clk_o));

   // R9
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_o |-> !clk_o);
endmodule

bind evendiv_clk_channel evendiv_clk_channel_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sync_n (sync_n),
   .pwrdn  (pwrdn),
   .clk_o  (clk_o),
   .off_o  (off_o),
   .hold   (hold_w),
   .act    (act_w),
   .div_q  (div_q_w)
);

// File: tb/evendiv_clk_channel_test.sv
`timescale 1ns/1ps
module evendiv_clk_channel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_n = 1'b1;
   logic [1:0] mode = 2'd0;
   logic [7:0] div_code = 8'd1;
   logic       ch_en = 1'b0;
   logic       glob_en_bit = 1'b0;
   logic       glob_en_pin = 1'b0;
   logic       pwrdn = 1'b0;
   logic       clk_o, off_o, cfg_bad_o;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit finished = 1'b0;

   always #5 clk = ~clk;

   evendiv_clk_channel uut (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mode(mode),
      .div_code(div_code), .ch_en(ch_en), .glob_en_bit(glob_en_bit),
      .glob_en_pin(glob_en_pin), .pwrdn(pwrdn),
      .clk_o(clk_o), .off_o(off_o), .cfg_bad_o(cfg_bad_o)
   );

   // behavioural reference: delay queue for qualified hold, phase index for divider
   bit  m_prev = 1'b1;
   bit  m_req  = 1'b0;
   bit  m_q[$] = '{0, 0, 0, 0};
   int  m_ph   = -1;
   bit  m_div  = 1'b0;

   function automatic bit is_div(input logic [1:0] m);
      return (m == 2'd1) || (m == 2'd3);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = 1'b1; m_req = 1'b0; m_q = '{0, 0, 0, 0};
         m_ph = -1; m_div = 1'b0;
      end else begin
         bit held;
         int n;
         held = m_q[3];
         n = (div_code == 0) ? 1 : int'(div_code);
         if (held || !is_div(mode)) begin
            m_ph = -1; m_div = 1'b0;
         end else begin
            m_ph = (m_ph + 1) % (2 * n);
            m_div = (m_ph < n);
         end
         if (sync_n) m_req = 1'b0;
         else if (!m_prev) m_req = 1'b1;
         m_prev = sync_n;
         m_q.push_front(m_req);
         void'(m_q.pop_back());
      end
   end

   task automatic chk(input string req, input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare(input bit lvl);
      bit live;
      bit exp_clk;
      live = ch_en & glob_en_bit & glob_en_pin & ~pwrdn;
      exp_clk = live & (is_div(mode) ? m_div : lvl);
      chk(cur_req, clk_o, exp_clk, "clk_o");
      chk(cur_req, off_o, ~live, "off_o");
      chk("R4", cfg_bad_o, (div_code == 8'd0), "cfg_bad_o");
   endtask

   initial begin
      forever begin
         @(posedge clk); #2 compare(1'b1);
         @(negedge clk); #2 compare(1'b0);
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enable_all();
      ch_en = 1'b1; glob_en_bit = 1'b1; glob_en_pin = 1'b1; pwrdn = 1'b0;
   endtask

   initial begin
      cur_req = "R1";
      run(3);
      #2 chk("R1", clk_o, 1'b0, "clk_o in reset");
      chk("R1", off_o, 1'b1, "off_o in reset");
      @(negedge clk) rst_n = 1'b1;
      run(4);

      enable_all();
      cur_req = "R2"; mode = 2'd0; run(10);
      mode = 2'd2; run(10);

      cur_req = "R11"; mode = 2'd1; div_code = 8'd3; run(3);
      cur_req = "R3"; run(30);
      mode = 2'd0; div_code = 8'd5; run(2);
      cur_req = "R11"; mode = 2'd3; run(3);
      cur_req = "R3"; run(40);

      mode = 2'd0; div_code = 8'd0; run(2);
      cur_req = "R4"; mode = 2'd1; run(12);
      mode = 2'd0; div_code = 8'd4; run(2);
      mode = 2'd1; run(11);

      cur_req = "R6"; sync_n = 1'b0; run(1); sync_n = 1'b1; run(12);
      cur_req = "R5"; sync_n = 1'b0; run(9);
      cur_req = "R7"; sync_n = 1'b1; run(20);
      cur_req = "R5"; sync_n = 1'b0; run(2); sync_n = 1'b1;
      cur_req = "R7"; run(15);

      cur_req = "R8"; mode = 2'd2; sync_n = 1'b0; run(10);
      mode = 2'd0; run(5); sync_n = 1'b1; run(6);

      cur_req = "R9"; mode = 2'd1; div_code = 8'd2;
      for (int c = 0; c < 8; c++) begin
         ch_en = c[0]; glob_en_bit = c[1]; glob_en_pin = c[2];
         run(6);
      end
      cur_req = "R10"; enable_all(); pwrdn = 1'b1; run(8);
      mode = 2'd0; run(6);
      pwrdn = 1'b0; cur_req = "R2"; run(4);

      div_code = 8'd255; run(2);
      cur_req = "R3"; mode = 2'd1; run(1100);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule